// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter

This block turns one byte at a time into a frame on a single asynchronous output line. Both ends of the link agree on the frame format in advance. A divider counts system clock cycles and holds every line bit for `CLK_FREQ/BAUD` cycles. A byte enters through a valid/ready handshake. The block then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. After that the line returns to its high idle level.

The parity mode and the stop-bit count are inputs, not build-time choices, so one instance can produce several frame formats. Both settings are captured together with the byte. Changing them while a frame is on the line has no effect on that frame.

Top module: `uart_tx`

## Requirements
- R1: After reset and between frames, `txLine` is 1, `inReady` is 1 and `busy` is 0.
- R2: A byte is accepted on a rising clock edge where `inValid` and `inReady` are both 1. From the next cycle, `txLine` is 0 (the start bit) for DIV = CLK_FREQ/BAUD cycles.
- R3: After the start bit, the DATA_W data bits are driven least significant bit first, each for DIV cycles.
- R4: `parityMode` selects the parity bit: 0 = none, 1 = even (data ones plus parity bit is even), 2 = odd (that total is odd), 3 = none. When enabled, the parity bit follows the last data bit and lasts DIV cycles.
- R5: The frame ends with stop bits at level 1, each DIV cycles long: one stop bit when `twoStop` is 0, two when it is 1.
- R6: `inReady` is 0 for exactly N*DIV cycles after acceptance, with N = 1 + DATA_W + (parity enabled ? 1 : 0) + (twoStop ? 2 : 1). With 8 data bits, no parity and one stop bit, N is 10.
- R7: `parityMode` and `twoStop` are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R8: `inValid` while `inReady` is 0 is ignored: no extra frame is produced for that data.
- R9: `busy` is always the inverse of `inReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte offered |
| inData | input | DATA_W | Byte to send |
| inReady | output | 1 | Block can accept a byte |
| parityMode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| twoStop | input | 1 | 1 selects two stop bits |
| txLine | output | 1 | Serial output line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with CLK_FREQ = 1,000,000 and BAUD = 125,000, so DIV is 8. This keeps each frame at 80 to 96 cycles, so frames in every parity mode and stop-bit count fit into a short run. With the short bit period, the decoder can sample each bit at its centre and can also count the exact ready-low window. The bench also changes the configuration in the middle of a frame and offers a stray byte while the block is busy.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_DATA,
    SEL_PAR,
    SEL_ONE
  } lineSel_t;

  typedef struct packed {
    logic     load;
    lineSel_t sel;
  } txStrb_t;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic [1:0] parityMode,
  input  logic       twoStop,
  output txStrb_t    strb,
  output logic       idle
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} state_t;

  state_t           state, stateNxt;
  logic [CNT_W-1:0] baudCnt;
  logic [IDX_W-1:0] bitIdx, bitIdxNxt;
  logic             stopIdx, stopIdxNxt;
  logic             parEnQ, twoStopQ;
  logic             tick;

  assign tick = (state != ST_IDLE) && (baudCnt == CNT_W'(DIV - 1));
  assign idle = (state == ST_IDLE);

  always_comb begin
    stateNxt   = state;
    bitIdxNxt  = bitIdx;
    stopIdxNxt = stopIdx;
    strb.load  = 1'b0;
    strb.sel   = SEL_HOLD;
    unique case (state)
      ST_IDLE: if (accept) begin
        strb.load = 1'b1;
        stateNxt  = ST_START;
      end
      ST_START: if (tick) begin
        stateNxt  = ST_DATA;
        bitIdxNxt = '0;
        strb.sel  = SEL_DATA;
      end
      ST_DATA: if (tick) begin
        if (bitIdx == IDX_W'(DATA_W - 1)) begin
          if (parEnQ) begin
            stateNxt = ST_PAR;
            strb.sel = SEL_PAR;
          end else begin
            stateNxt   = ST_STOP;
            stopIdxNxt = 1'b0;
            strb.sel   = SEL_ONE;
          end
        end else begin
          bitIdxNxt = bitIdx + 1'b1;
          strb.sel  = SEL_DATA;
        end
      end
      ST_PAR: if (tick) begin
        stateNxt   = ST_STOP;
        stopIdxNxt = 1'b0;
        strb.sel   = SEL_ONE;
      end
      ST_STOP: if (tick) begin
        if (twoStopQ && !stopIdx) stopIdxNxt = 1'b1;
        else                      stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      baudCnt  <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitIdx  <= bitIdxNxt;
      stopIdx <= stopIdxNxt;
      if (strb.load || tick) baudCnt <= '0;
      else if (state != ST_IDLE) baudCnt <= baudCnt + 1'b1;
      if (strb.load) begin
        parEnQ   <= (parityMode == PAR_EVEN) || (parityMode == PAR_ODD);
        twoStopQ <= twoStop;
      end
    end
  end
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [1:0]        parityMode,
  output logic              txLine
);
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      txLine   <= 1'b1;
    end else if (strb.load) begin
      shiftReg <= inData;
      parBit   <= (parityMode == PAR_ODD) ? ~(^inData) : (^inData);
      txLine   <= 1'b0;
    end else begin
      unique case (strb.sel)
        SEL_DATA: begin
          txLine   <= shiftReg[0];
          shiftReg <= shiftReg >> 1;
        end
        SEL_PAR: txLine <= parBit;
        SEL_ONE: txLine <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int CLK_FREQ = 50_000_000,
  parameter int BAUD     = 115_200,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  input  logic [1:0]        parityMode,
  input  logic              twoStop,
  output logic              txLine,
  output logic              busy
);
  localparam int DIV = CLK_FREQ / BAUD;

  txStrb_t strb;
  logic    idle;

  assign inReady = idle;
  assign busy    = !idle;

  uart_tx_ctrl #(.DIV(DIV), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accept(inValid), .parityMode(parityMode),
    .twoStop(twoStop), .strb(strb), .idle(idle)
  );

  uart_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .parityMode(parityMode), .txLine(txLine)
  );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic txLine,
  input logic busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!txLine && busy)); // R2
  AST_END_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(txLine)); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && inValid) |=> $stable(inReady) || !busy); // R8
  AST_READY_INV: assert property (@(posedge clk) disable iff (!rstN)
    inReady != busy); // R9
endmodule

bind uart_tx uart_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .txLine(txLine), .busy(busy)
);

// File: tb/uart_tx_bench.sv
module uart_tx_bench;
  localparam int CLK_FREQ = 1_000_000;
  localparam int BAUD     = 125_000;
  localparam int DIV      = CLK_FREQ / BAUD;
  localparam int W        = 8;

  typedef struct {
    logic [W-1:0] data;
    logic [1:0]   mode;
    logic         two;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, txLine, busy;
  logic [1:0] parityMode = 2'd0;
  logic twoStop = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  uart_tx #(.CLK_FREQ(CLK_FREQ), .BAUD(BAUD), .DATA_W(W)) u_uart_tx (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .parityMode(parityMode), .twoStop(twoStop),
    .txLine(txLine), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [W-1:0] d, logic [1:0] m, logic t, bit flipCfg);
    int cnt;
    int nBits;
    bit busyOk;
    @(negedge clk);
    inValid = 1'b1; inData = d; parityMode = m; twoStop = t;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    expQ.push_back('{data: d, mode: m, two: t});
    @(negedge clk);
    inValid = 1'b0;
    if (flipCfg) begin // R7: change config mid-frame
      parityMode = (m == 2'd1) ? 2'd2 : 2'd1;
      twoStop = ~t;
    end
    nBits = 1 + W + ((m == 2'd1 || m == 2'd2) ? 1 : 0) + (t ? 2 : 1);
    cnt = 0;
    busyOk = 1;
    while (!inReady) begin
      if (!busy) busyOk = 0;
      cnt++;
      @(negedge clk);
    end
    check("R6 ready-low cycles", cnt, nBits * DIV);
    check("R9 busy inverse of ready", busyOk, 1);
    check("R1 idle line between frames", {txLine, busy}, 2'b10);
  endtask

  // monitor: decode serial line, compare with scoreboard
  initial begin : monitor
    item_t it;
    logic [W-1:0] got;
    logic expPar;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (txLine == 1'b0) begin
        if (expQ.size() == 0) begin
          check("R8 unexpected frame", 1, 0);
          it = '{data: '0, mode: 2'd0, two: 1'b0};
        end else it = expQ.pop_front();
        repeat (DIV / 2) @(negedge clk);
        check("R2 start bit", txLine, 0);
        for (int i = 0; i < W; i++) begin
          repeat (DIV) @(negedge clk);
          got[i] = txLine;
        end
        check("R3 data lsb first", got, it.data);
        if (it.mode == 2'd1 || it.mode == 2'd2) begin
          repeat (DIV) @(negedge clk);
          expPar = (it.mode == 2'd2) ? ~(^it.data) : (^it.data);
          check("R4 parity bit", txLine, expPar);
        end
        repeat (DIV) @(negedge clk);
        check("R5 first stop bit", txLine, 1);
        if (it.two) begin
          repeat (DIV) @(negedge clk);
          check("R5 second stop bit", txLine, 1);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", {txLine, inReady, busy}, 3'b110);
    send(8'h4F, 2'd0, 1'b0, 0);   // 8N1 'O'
    send(8'h4B, 2'd0, 1'b0, 0);   // 8N1 'K'
    send(8'h4F, 2'd1, 1'b0, 0);   // R4 even
    send(8'h4B, 2'd2, 1'b0, 0);   // R4 odd
    send(8'h00, 2'd2, 1'b1, 0);   // R4 odd all zero, R5 two stop
    send(8'hFF, 2'd1, 1'b1, 0);   // R4 even all ones
    send(8'hA5, 2'd3, 1'b0, 0);   // R4 mode 3 = none
    send(8'h3C, 2'd0, 1'b1, 1);   // R7 cfg flip mid-frame
    send(8'h81, 2'd1, 1'b0, 1);   // R7 cfg flip mid-frame
    // R8: offer a stray byte while busy; it must produce no frame
    fork
      send(8'h5A, 2'd2, 1'b1, 0);
      begin
        repeat (3 * DIV) @(negedge clk);
        inValid = 1'b1; inData = 8'hC3;
        repeat (4) @(negedge clk);
        check("R8 ready stays low while busy", inReady, 0);
        inValid = 1'b0;
      end
    join
    repeat (20 * DIV) @(negedge clk);
    check("R8 no pending frames", expQ.size(), 0);
    check("R1 final idle", {txLine, inReady, busy}, 3'b110);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule